// File: doc/BRIEF.md
# Bit-Serial Dot-Product Accumulator

This unit computes dot products for quantized neural-network kernels on a 32-bit microcontroller datapath, and it does so without a multiplier. Each step takes two packed 32-bit words in which every bit is one lane of a weight or activation bit plane. The unit combines the two words with a bitwise logic operation that depends on the mode. It counts the ones in the result, scales that count with shifts and subtraction, and adds the scaled count to a running signed accumulator.

Software issues one step for each bit-plane pair. In mixed-precision mode it supplies the plane indices and flags the planes that hold a two's-complement sign bit, so operands of any width up to eight bits can be reduced one plane at a time. The same datapath also handles binary (±1) lanes and ternary weights paired with binary activations. Ternary weights use an extra non-zero mask word. A clear input restarts the sum. A last marker on the final step makes the unit raise a done flag.

Top module: `bsdp_unit`

## Requirements
- R1: While `rst_ni` is low and after its release with no step, `acc_o` is 0 and `done_o` is 0.
- R2: `clear_i` high at a rising edge sets `acc_o` to 0 and overrides a simultaneous `valid_i`.
- R3: Binary mode (`mode_i`=0): a step adds 2·popcount(~(a ^ b)) − 32 to the accumulator.
- R4: Ternary mode (`mode_i`=1): a step adds popcount(mask) − 2·popcount(mask & (a ^ b)). `mask_i` bit l marks lane l as non-zero, and `op_a_i` and `op_b_i` carry the weight and activation signs.
- R5: Mixed mode (`mode_i`=2): a step computes popcount(a & b) shifted left by `wplane_i` + `aplane_i`. It adds that value, or subtracts it when exactly one of `wneg_i` and `aneg_i` is set.
- R6: Each rising edge with `valid_i` high and `clear_i` low applies exactly one step. With neither input high, `acc_o` holds its value.
- R7: `done_o` is high in the cycle after an edge where `valid_i` and `last_i` are high and `clear_i` is low, and low in every other cycle.
- R8: The accumulator is 32-bit two's complement and wraps modulo 2^32 without saturating.
- R9: A step with the reserved `mode_i`=3 leaves `acc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero the accumulator |
| valid_i | input | 1 | Apply one step this cycle |
| last_i | input | 1 | Marks the final step of a dot product |
| mode_i | input | 2 | 0 binary, 1 ternary, 2 mixed, 3 reserved |
| op_a_i | input | 32 | Weight bit plane (sign plane in ternary) |
| op_b_i | input | 32 | Activation bit plane |
| mask_i | input | 32 | Ternary non-zero lane mask |
| wplane_i | input | 3 | Weight bit-plane index (mixed mode) |
| aplane_i | input | 3 | Activation bit-plane index (mixed mode) |
| wneg_i | input | 1 | Weight plane is a sign-bit plane |
| aneg_i | input | 1 | Activation plane is a sign-bit plane |
| acc_o | output | 32 | Signed running accumulator |
| done_o | output | 1 | Final step has been applied |

## Verification
A wrong logic operation, popcount or scaling term changes `acc_o` by the wrong amount on the edge that applies the step. The bench compares the accumulator after every step, so such an error shows up on the first affected cycle and is not hidden inside a later total. Sign and shift errors in mixed mode are also caught over a complete 4-bit by 4-bit signed dot product, which is compared with a plain sum of lane products. Wrap and hold faults show up as a mismatch at the 4096th large step, or in the cycle after an idle or reserved-mode edge.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  typedef enum logic [1:0] {
    MODE_BIN = 2'd0,
    MODE_TER = 2'd1,
    MODE_MIX = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;
endpackage

// File: rtl/bsdp_combine.sv
module bsdp_combine
  import bsdp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  mode_e             mode_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    unique case (mode_i)
      MODE_BIN: word_o = ~(op_a_i ^ op_b_i);
      MODE_TER: word_o = mask_i & (op_a_i ^ op_b_i);
      MODE_MIX: word_o = op_a_i & op_b_i;
      default:  word_o = '0;
    endcase
  end
endmodule

// File: rtl/bsdp_popcount.sv
module bsdp_popcount #(
  parameter int WORD_W = 32,
  localparam int PC_W  = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [PC_W-1:0]   count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < WORD_W; i++) begin
      count_o = count_o + PC_W'(word_i[i]);
    end
  end
endmodule

// File: rtl/bsdp_scale.sv
module bsdp_scale
  import bsdp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 32,
  parameter int IDX_W  = 3,
  localparam int PC_W  = $clog2(WORD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic [PC_W-1:0]  pc_main_i,
  input  logic [PC_W-1:0]  pc_mask_i,
  input  logic [IDX_W-1:0] wplane_i,
  input  logic [IDX_W-1:0] aplane_i,
  input  logic             wneg_i,
  input  logic             aneg_i,
  output logic [ACC_W-1:0] term_o
);
  localparam logic [ACC_W-1:0] WORD_C = ACC_W'(WORD_W);

  logic [IDX_W:0]   sh_amt;
  logic [ACC_W-1:0] main_ext, mask_ext, mag;

  assign sh_amt   = {1'b0, wplane_i} + {1'b0, aplane_i};
  assign main_ext = ACC_W'(pc_main_i);
  assign mask_ext = ACC_W'(pc_mask_i);
  assign mag      = main_ext << sh_amt;

  always_comb begin
    unique case (mode_i)
      MODE_BIN: term_o = (main_ext << 1) - WORD_C;
      MODE_TER: term_o = mask_ext - (main_ext << 1);
      MODE_MIX: term_o = (wneg_i ^ aneg_i) ? ('0 - mag) : mag;
      default:  term_o = '0;
    endcase
  end

  AST_BIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BIN) |-> ($signed(term_o) >= -WORD_W && $signed(term_o) <= WORD_W)); // R3
  AST_TER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TER) |-> ($signed(term_o) >= -WORD_W && $signed(term_o) <= WORD_W)); // R4
endmodule

// File: rtl/bsdp_unit.sv
module bsdp_unit
  import bsdp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 32,
  parameter int IDX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [1:0]       mode_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [IDX_W-1:0] wplane_i,
  input  logic [IDX_W-1:0] aplane_i,
  input  logic             wneg_i,
  input  logic             aneg_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             done_o
);
  localparam int PC_W = $clog2(WORD_W + 1);

  mode_e             mode;
  logic [WORD_W-1:0] comb_word;
  logic [PC_W-1:0]   pc_main, pc_mask;
  logic [ACC_W-1:0]  term, acc_q;
  logic              done_q;

  assign mode = mode_e'(mode_i);

  bsdp_combine #(.WORD_W(WORD_W)) u_combine (
    .mode_i (mode),
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .mask_i (mask_i),
    .word_o (comb_word)
  );

  bsdp_popcount #(.WORD_W(WORD_W)) u_pc_main (
    .word_i  (comb_word),
    .count_o (pc_main)
  );

  bsdp_popcount #(.WORD_W(WORD_W)) u_pc_mask (
    .word_i  (mask_i),
    .count_o (pc_mask)
  );

  bsdp_scale #(.WORD_W(WORD_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_scale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .pc_main_i (pc_main),
    .pc_mask_i (pc_mask),
    .wplane_i  (wplane_i),
    .aplane_i  (aplane_i),
    .wneg_i    (wneg_i),
    .aneg_i    (aneg_i),
    .term_o    (term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i & last_i & ~clear_i;
      if (clear_i)      acc_q <= '0;
      else if (valid_i) acc_q <= acc_q + term;  // wraps
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_o == '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> $stable(acc_o)); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && last_i && !clear_i)); // R7
  AST_RESERVED_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && mode_i == 2'd3) |=> $stable(acc_o)); // R9
endmodule

// File: tb/bsdp_unit_bench.sv
`timescale 1ns/1ps
module bsdp_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [31:0] op_a_i = '0, op_b_i = '0, mask_i = '0;
  logic [2:0]  wplane_i = '0, aplane_i = '0;
  logic        wneg_i = 1'b0, aneg_i = 1'b0;
  logic [31:0] acc_o;
  logic        done_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model = '0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  bsdp_unit u_bsdp_unit (
    .clk_i, .rst_ni, .clear_i, .valid_i, .last_i, .mode_i,
    .op_a_i, .op_b_i, .mask_i, .wplane_i, .aplane_i,
    .wneg_i, .aneg_i, .acc_o, .done_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic [31:0] term_of(input logic [1:0] m, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] k, input int wp, input int ap,
      input logic wn, input logic an);
    int v;
    case (m)
      2'd0: v = 2 * $countones(~(a ^ b)) - 32;
      2'd1: v = $countones(k) - 2 * $countones(k & (a ^ b));
      2'd2: begin
        v = $countones(a & b) << (wp + ap);
        if (wn ^ an) v = -v;
      end
      default: v = 0;
    endcase
    return 32'(v);
  endfunction

  // one step; drives at negedge, checks at following negedge
  task automatic step(input string tag, input logic [1:0] m, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] k, input int wp, input int ap,
      input logic wn, input logic an, input logic lst);
    mode_i = m; op_a_i = a; op_b_i = b; mask_i = k;
    wplane_i = 3'(wp); aplane_i = 3'(ap); wneg_i = wn; aneg_i = an;
    last_i = lst; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; last_i = 1'b0;
    model = model + term_of(m, a, b, k, wp, ap, wn, an);
    chk(tag, acc_o, model);
    chk("R7 done", 32'(done_o), 32'(lst));
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    model = '0;
    chk("R2 clear", acc_o, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb, rk;
    logic signed [3:0] wv [32];
    logic signed [3:0] av [32];
    int dot;
    logic [31:0] wpl, apl;

    #35;
    chk("R1 reset acc", acc_o, 32'd0);
    chk("R1 reset done", 32'(done_o), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", acc_o, 32'd0);
    chk("R1 done idle", 32'(done_o), 32'd0);

    // R3 binary corner and mixed patterns
    step("R3 all agree", 2'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F, '0, 0, 0, 0, 0, 0);
    step("R3 all differ", 2'd0, 32'h0000_FFFF, 32'hFFFF_0000, '0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      ra = $urandom; rb = $urandom;
      step("R3 random", 2'd0, ra, rb, '0, 0, 0, 0, 0, i == 39);
    end
    @(negedge clk_i);
    chk("R7 done drops", 32'(done_o), 32'd0);
    chk("R6 idle hold", acc_o, model);

    // R4 ternary
    do_clear();
    step("R4 zero mask", 2'd1, $urandom, $urandom, '0, 0, 0, 0, 0, 0);
    step("R4 full mask agree", 2'd1, 32'h1234_5678, 32'h1234_5678, '1, 0, 0, 0, 0, 0);
    step("R4 full mask differ", 2'd1, 32'h0, '1, '1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      ra = $urandom; rb = $urandom; rk = $urandom;
      step("R4 random", 2'd1, ra, rb, rk, 0, 0, 0, 0, 0);
    end

    // R5 sweep of plane pairs and sign flags
    do_clear();
    for (int wp = 0; wp < 8; wp++)
      for (int ap = 0; ap < 8; ap++)
        for (int s = 0; s < 4; s++) begin
          ra = $urandom; rb = $urandom;
          step("R5 sweep", 2'd2, ra, rb, '0, wp, ap, s[1], s[0], 0);
        end

    // R5 full 4x4-bit signed dot product against plain products
    do_clear();
    dot = 0;
    for (int l = 0; l < 32; l++) begin
      wv[l] = 4'($urandom); av[l] = 4'($urandom);
      dot += int'(wv[l]) * int'(av[l]);
    end
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++) begin
        for (int l = 0; l < 32; l++) begin
          wpl[l] = wv[l][p]; apl[l] = av[l][q];
        end
        step("R5 plane", 2'd2, wpl, apl, '0, p, q, p == 3, q == 3, p == 3 && q == 3);
      end
    chk("R5 signed dot", acc_o, 32'(dot));

    // R9 reserved mode, R2 clear priority
    step("R9 reserved", 2'd3, '1, '1, '1, 7, 7, 0, 0, 0);
    chk("R9 unchanged", acc_o, 32'(dot));
    clear_i = 1'b1; valid_i = 1'b1; last_i = 1'b1; mode_i = 2'd0;
    @(negedge clk_i);
    clear_i = 1'b0; valid_i = 1'b0; last_i = 1'b0; model = '0;
    chk("R2 clear beats valid", acc_o, 32'd0);
    chk("R7 no done on clear", 32'(done_o), 32'd0);

    // R8 wrap: 2^19 per step
    for (int i = 0; i < 4100; i++) begin
      step("R8 accumulate", 2'd2, '1, '1, '0, 7, 7, 0, 0, 0);
      if (i == 4095) chk("R8 reach 2^31", acc_o, 32'h8000_0000);
    end
    chk("R8 wrapped", acc_o, 32'h8000_0000 + 32'd4 * 32'h0008_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule